// File: doc/BRIEF.md
# Dual-Bank SDRAM Controller

This block lets a host read and write single 16-bit words in a two-bank synchronous DRAM. It uses a request port with a valid/ready handshake and a one-cycle response pulse. After reset it holds the clock enable low, then raises it and waits a programmable stable-clock time. It then closes all rows, issues two auto-refresh commands and writes the mode register. Only after that does it accept host requests.

Each host access opens the addressed row and issues one column command with auto-precharge set. The block then waits out the recovery time, so every row is closed again when the block returns to idle. A refresh timer raises a pending flag once per refresh interval. That flag takes priority over a waiting host request. The refresh itself is a precharge-all followed by an auto-refresh. Host byte enables become per-lane DQM levels on writes. Reads use both lanes, and their data is captured a programmable CAS latency (2 or 3) after the command reaches the memory.

Top module: `sdc_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sd_cke_o` is low and `req_ready_o` is low. After release, the block issues no command other than NOP for at least `T_PWR` cycles. Its first four commands are then: precharge with A10=1, auto-refresh, auto-refresh, mode register set. `req_ready_o` stays low until the mode register set has been issued.
- R2: The mode register set drives BA=0 and address bits [6:4] = `CAS_LAT`, with all other address bits 0 (burst length 1, sequential order). The next command follows at least `T_MRD` cycles later.
- R3: Commands are encoded on {CS#,RAS#,CAS#,WE#}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, MODE SET 0000.
- R4: Host address bit 19 selects the bank. Bits [18:8] are the row, driven on ACTIVE. Bits [7:0] are the column, driven on READ/WRITE. A10 is 1 on every READ/WRITE (auto-precharge).
- R5: A READ or WRITE follows the ACTIVE of its request by at least `T_RCD` cycles.
- R6: A WRITE drives `req_wdata_i` on `sd_dq_o` with `sd_dq_oe_o`=1 in the same cycle. `sd_dqm_o[i]` is the inverse of `req_be_i[i]`, so lanes with enable 0 are left unchanged in memory.
- R7: A READ drives `sd_dqm_o`=00. The data present at the memory `CAS_LAT` cycles after the command is sampled is returned on `rsp_rdata_o`, and `rsp_valid_o` is a single-cycle pulse.
- R8: Every auto-refresh after initialisation is preceded by a precharge with A10=1 at least `T_RP` cycles earlier. Consecutive refreshes are no more than `REF_INT` plus one access time apart, even under continuous host traffic.
- R9: Every command other than NOP is issued while `sd_cke_o` has been high for at least one full cycle.
- R10: A request is taken only on a cycle with `req_valid_i` and `req_ready_o` both high. `req_ready_o` is low in the cycle after a request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | {bank, row[10:0], column[7:0]} |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 1 = upper lane |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 16 | Read data |
| sd_cke_o | output | 1 | Memory clock enable |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | 1 | Bank select |
| sd_addr_o | output | 11 | Multiplexed row/column address |
| sd_dqm_o | output | 2 | Per-lane data mask |
| sd_dq_o | output | 16 | Write data to memory |
| sd_dq_oe_o | output | 1 | Data output enable |
| sd_dq_i | input | 16 | Read data from memory |

## Verification
Directed accesses go to the address corners: bank 1 with the last row and last column, and bank 0 with row 0 and column 0. These show whether the bank, row and column fields land on the correct pins and show up a swapped or truncated field. Partial writes with byte enables 01, 10 and 00, each followed by a read-back, separate a correct lane mapping from an inverted or swapped mask. Random reads and writes over a small pool of addresses force reuse of the same words and interleave the two banks, so a stale value or a wrong capture latency shows up as a data mismatch. The traffic runs long enough for refreshes to arrive while host requests are waiting.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_PWR, ST_PRE, ST_REF, ST_MRS, ST_IDLE, ST_ACT, ST_RW, ST_WAIT
  } st_e;
endpackage

// File: rtl/sdc_ref_timer.sv
module sdc_ref_timer #(
  parameter int REF_INT = 1560,
  localparam int CW = $clog2(REF_INT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic pend_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= CW'(REF_INT - 1);
      pend_o <= 1'b0;
    end else begin
      if (cnt_q == '0) begin
        cnt_q  <= CW'(REF_INT - 1);
        pend_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (clr_i) pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdc_rd_pipe.sv
module sdc_rd_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,   // READ currently on the pins
  input  logic [DW-1:0] dq_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  logic [CAS_LAT-1:0] vld_q;

  generate
    if (CAS_LAT == 1) begin : g_l1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) vld_q <= '0;
        else         vld_q <= issue_i;
    end else begin : g_ln
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) vld_q <= '0;
        else         vld_q <= {vld_q[CAS_LAT-2:0], issue_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= vld_q[CAS_LAT-1];
      if (vld_q[CAS_LAT-1]) data_o <= dq_i;
    end
  end
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl import sdc_pkg::*; #(
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int DW        = 16,
  parameter int CAS_LAT   = 2,
  parameter int T_PWR     = 20,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 7,
  parameter int T_MRD     = 2,
  parameter int T_RCD     = 2,
  parameter int T_WR      = 1,
  parameter int REF_INT   = 1560,
  parameter int INIT_REFS = 2,
  localparam int AW = 1 + ROW_W + COL_W,
  localparam int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [NB-1:0] req_be_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          sd_cke_o,
  output logic          sd_cs_no,
  output logic          sd_ras_no,
  output logic          sd_cas_no,
  output logic          sd_we_no,
  output logic          sd_ba_o,
  output logic [ROW_W-1:0] sd_addr_o,
  output logic [NB-1:0] sd_dqm_o,
  output logic [DW-1:0] sd_dq_o,
  output logic          sd_dq_oe_o,
  input  logic [DW-1:0] sd_dq_i
);
  localparam int AP_BIT = 10;
  // wait-state loads: command spacing n costs n-2 extra WAIT cycles (min spacing 2)
  localparam int G_RP  = (T_RP  < 2) ? 0 : T_RP  - 2;
  localparam int G_RFC = (T_RFC < 2) ? 0 : T_RFC - 2;
  localparam int G_MRD = (T_MRD < 2) ? 0 : T_MRD - 2;
  localparam int G_RCD = (T_RCD < 2) ? 0 : T_RCD - 2;
  localparam int G_WRC = (T_WR + T_RP < 2) ? 0 : T_WR + T_RP - 2;
  localparam int G_RDC = (CAS_LAT + T_RP < 2) ? 0 : CAS_LAT + T_RP - 2;
  localparam int CW = $clog2(T_PWR + T_RFC + T_MRD + T_RCD + T_WR + T_RP + CAS_LAT + 2);
  localparam int RW = $clog2(INIT_REFS + 1);

  st_e              st_q, ret_q;
  cmd_e             cmd_q;
  logic [CW-1:0]    cnt_q;
  logic [RW-1:0]    iref_q;
  logic             init_done_q, cke_q, ba_q, oe_q;
  logic [ROW_W-1:0] addr_q;
  logic [NB-1:0]    dqm_q;
  logic [DW-1:0]    dq_q;
  logic             r_we_q;
  logic [AW-1:0]    r_addr_q;
  logic [DW-1:0]    r_wdata_q;
  logic [NB-1:0]    r_be_q;
  logic             ref_pend;

  assign req_ready_o = (st_q == ST_IDLE) && init_done_q && !ref_pend;

  sdc_ref_timer #(.REF_INT(REF_INT)) u_ref (
    .clk_i, .rst_ni, .clr_i(st_q == ST_REF), .pend_o(ref_pend)
  );

  sdc_rd_pipe #(.CAS_LAT(CAS_LAT), .DW(DW)) u_rd (
    .clk_i, .rst_ni, .issue_i(cmd_q == CMD_RD), .dq_i(sd_dq_i),
    .valid_o(rsp_valid_o), .data_o(rsp_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_PWR;
      ret_q       <= ST_PRE;
      cnt_q       <= CW'(T_PWR - 1);
      iref_q      <= '0;
      init_done_q <= 1'b0;
      cke_q       <= 1'b0;
      cmd_q       <= CMD_NOP;
      ba_q        <= 1'b0;
      addr_q      <= '0;
      dqm_q       <= '0;
      dq_q        <= '0;
      oe_q        <= 1'b0;
      r_we_q      <= 1'b0;
      r_addr_q    <= '0;
      r_wdata_q   <= '0;
      r_be_q      <= '0;
    end else begin
      cke_q <= 1'b1;
      cmd_q <= CMD_NOP;
      oe_q  <= 1'b0;
      dqm_q <= '0;
      unique case (st_q)
        ST_PWR: begin
          if (cnt_q == '0) st_q <= ST_PRE;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_PRE: begin
          cmd_q          <= CMD_PRE;
          addr_q         <= '0;
          addr_q[AP_BIT] <= 1'b1;      // all banks
          cnt_q          <= CW'(G_RP);
          ret_q          <= ST_REF;
          st_q           <= ST_WAIT;
        end
        ST_REF: begin
          cmd_q <= CMD_REF;
          cnt_q <= CW'(G_RFC);
          st_q  <= ST_WAIT;
          if (init_done_q) ret_q <= ST_IDLE;
          else begin
            iref_q <= iref_q + 1'b1;
            ret_q  <= (iref_q == RW'(INIT_REFS - 1)) ? ST_MRS : ST_REF;
          end
        end
        ST_MRS: begin
          cmd_q       <= CMD_MRS;
          ba_q        <= 1'b0;
          addr_q      <= '0;
          addr_q[6:4] <= 3'(CAS_LAT);  // BL=1, sequential
          cnt_q       <= CW'(G_MRD);
          ret_q       <= ST_IDLE;
          st_q        <= ST_WAIT;
          init_done_q <= 1'b1;
        end
        ST_IDLE: begin
          if (ref_pend) st_q <= ST_PRE;
          else if (req_valid_i) begin
            r_we_q    <= req_we_i;
            r_addr_q  <= req_addr_i;
            r_wdata_q <= req_wdata_i;
            r_be_q    <= req_be_i;
            st_q      <= ST_ACT;
          end
        end
        ST_ACT: begin
          cmd_q  <= CMD_ACT;
          ba_q   <= r_addr_q[AW-1];
          addr_q <= r_addr_q[COL_W +: ROW_W];
          cnt_q  <= CW'(G_RCD);
          ret_q  <= ST_RW;
          st_q   <= ST_WAIT;
        end
        ST_RW: begin
          addr_q              <= '0;
          addr_q[COL_W-1:0]   <= r_addr_q[COL_W-1:0];
          addr_q[AP_BIT]      <= 1'b1;
          ret_q               <= ST_IDLE;
          st_q                <= ST_WAIT;
          if (r_we_q) begin
            cmd_q <= CMD_WR;
            dq_q  <= r_wdata_q;
            oe_q  <= 1'b1;
            dqm_q <= ~r_be_q;
            cnt_q <= CW'(G_WRC);
          end else begin
            cmd_q <= CMD_RD;
            cnt_q <= CW'(G_RDC);
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) st_q <= ret_q;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_PWR;
      endcase
    end
  end

  assign sd_cke_o   = cke_q;
  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd_q;
  assign sd_ba_o    = ba_q;
  assign sd_addr_o  = addr_q;
  assign sd_dqm_o   = dqm_q;
  assign sd_dq_o    = dq_q;
  assign sd_dq_oe_o = oe_q;
endmodule

// File: rtl/sdc_ctrl_chk.sv
module sdc_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sd_cke_o,
  input logic        sd_cs_no,
  input logic        sd_ras_no,
  input logic        sd_cas_no,
  input logic        sd_we_no,
  input logic [10:0] sd_addr_o,
  input logic [1:0]  sd_dqm_o,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o
);
  logic [3:0] cmd;
  logic       closed_q;
  assign cmd = {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) closed_q <= 1'b0;
    else if (cmd == 4'b0010 && sd_addr_o[10]) closed_q <= 1'b1;
    else if (cmd == 4'b0011) closed_q <= 1'b0;

  a_r9_cke_before_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd != 4'b0111) |-> (sd_cke_o && $past(sd_cke_o)));
  a_r2_mrs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0000) |=> (cmd == 4'b0111));
  a_r4_auto_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0101 || cmd == 4'b0100) |-> sd_addr_o[10]);
  a_r7_rd_nomask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0101) |-> (sd_dqm_o == 2'b00));
  a_r8_ref_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == 4'b0001) |-> closed_q);
  a_r7_rsp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r10_ready_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
endmodule

bind sdc_ctrl sdc_ctrl_chk u_chk (
  .clk_i, .rst_ni, .sd_cke_o, .sd_cs_no, .sd_ras_no, .sd_cas_no, .sd_we_no,
  .sd_addr_o, .sd_dqm_o, .req_valid_i, .req_ready_o, .rsp_valid_o
);

// File: tb/tb_sdc_ctrl.sv
module tb_sdc_ctrl;
  localparam int CL = 2, T_PWR = 20, T_RP = 2, T_MRD = 2, T_RCD = 2, REF_INT = 1560;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, cke, cs_n, ras_n, cas_n, we_n, ba, dq_oe;
  logic [15:0] rsp_rdata, dq_o;
  logic [15:0] dq_drv = '0;
  logic [10:0] sd_addr;
  logic [1:0]  dqm;

  always #5 clk = ~clk;

  sdc_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .sd_cke_o(cke), .sd_cs_no(cs_n),
    .sd_ras_no(ras_n), .sd_cas_no(cas_n), .sd_we_no(we_n), .sd_ba_o(ba),
    .sd_addr_o(sd_addr), .sd_dqm_o(dqm), .sd_dq_o(dq_o), .sd_dq_oe_o(dq_oe), .sd_dq_i(dq_drv)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] merge(logic [15:0] old, logic [15:0] nw, logic [1:0] be);
    return {be[1] ? nw[15:8] : old[15:8], be[0] ? nw[7:0] : old[7:0]};
  endfunction

  logic [15:0] gold [int];
  logic [15:0] mdl  [int];
  function automatic logic [15:0] gget(int k);
    return gold.exists(k) ? gold[k] : 16'h0;
  endfunction
  function automatic logic [15:0] mget(int k);
    return mdl.exists(k) ? mdl[k] : 16'h0;
  endfunction

  // memory model and protocol monitor, sampled at negedge
  int cyc = 0, rel_cyc = 0, ncmd = 0, act_cyc = -100, mrs_cyc = -100, pre_cyc = -100;
  int last_ref = -1, n_ref = 0, rd_cnt = 0;
  logic [15:0] rd_dat;
  logic prev_cke = 0;
  logic [10:0] act_row;
  logic act_ba;
  logic [19:0] exp_addr;
  logic exp_we;
  logic [15:0] exp_wd;
  logic [1:0] exp_be;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    if (rd_cnt == 1) dq_drv <= rd_dat; else dq_drv <= 16'h0;
    if (rd_cnt > 0) rd_cnt--;
    if (!rst_n) begin
      if (cyc == 2) begin
        chk(cke == 1'b0, "R1 cke low in reset", cke, 0);
        chk(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
      end
    end else begin
      if (ncmd < 4 && req_ready) chk(0, "R1 ready before mode set", 1, 0);
      if (c != 4'b0111) begin
        chk(cke && prev_cke, "R9 cke high before cmd", {cke, prev_cke}, 2'b11);
        if (mrs_cyc >= 0 && ncmd == 4)
          chk(cyc - mrs_cyc >= T_MRD, "R2 gap after mode set", cyc - mrs_cyc, T_MRD);
        case (ncmd)
          0: begin
            chk(cyc - rel_cyc >= T_PWR, "R1 power wait", cyc - rel_cyc, T_PWR);
            chk(c == 4'b0010 && sd_addr[10], "R1 first cmd precharge-all", {c, sd_addr[10]}, 5'b00101);
          end
          1, 2: chk(c == 4'b0001, "R1 init refresh", c, 4'b0001);
          3: begin
            chk(c == 4'b0000, "R1 mode set fourth", c, 4'b0000);
            chk({ba, sd_addr} == 12'(CL << 4), "R2 mode operand", {ba, sd_addr}, CL << 4);
            mrs_cyc = cyc;
          end
          default: ;
        endcase
        ncmd++;
        case (c)
          4'b0010: pre_cyc = cyc;
          4'b0001: begin
            if (ncmd > 4) begin
              chk(cyc - pre_cyc >= T_RP, "R8 precharge before refresh", cyc - pre_cyc, T_RP);
              if (last_ref >= 0)
                chk(cyc - last_ref <= REF_INT + 24, "R8 refresh interval", cyc - last_ref, REF_INT + 24);
              n_ref++;
            end
            last_ref = cyc;
          end
          4'b0011: begin
            act_cyc = cyc; act_row = sd_addr; act_ba = ba;
            chk({ba, sd_addr} == exp_addr[19:8], "R4 bank/row on ACTIVE", {ba, sd_addr}, exp_addr[19:8]);
          end
          4'b0100, 4'b0101: begin
            int k;
            k = int'({act_ba, act_row, sd_addr[7:0]});
            chk(cyc - act_cyc >= T_RCD, "R5 ACTIVE to column", cyc - act_cyc, T_RCD);
            chk(c == (exp_we ? 4'b0100 : 4'b0101), "R3 column command code", c, exp_we ? 4'b0100 : 4'b0101);
            chk({ba, sd_addr[10], sd_addr[7:0]} == {exp_addr[19], 1'b1, exp_addr[7:0]},
                "R4 bank/col/A10 on column cmd", {ba, sd_addr[10], sd_addr[7:0]}, {exp_addr[19], 1'b1, exp_addr[7:0]});
            if (c == 4'b0100) begin
              chk(dq_oe && dq_o == exp_wd, "R6 write data", {dq_oe, dq_o}, {1'b1, exp_wd});
              chk(dqm == ~exp_be, "R6 write mask", dqm, ~exp_be);
              mdl[k] = merge(mget(k), dq_o, ~dqm);
            end else begin
              chk(dqm == 2'b00, "R7 read mask", dqm, 0);
              rd_dat = mget(k);
              rd_cnt = CL;
            end
          end
          default: ;
        endcase
      end
    end
    prev_cke = cke;
  end

  task automatic issue(logic we, logic [19:0] a, logic [15:0] d, logic [1:0] be);
    do @(negedge clk); while (!req_ready);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    exp_addr = a; exp_we = we; exp_wd = d; exp_be = be;
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 0, "R10 ready drops after accept", req_ready, 0);
  endtask

  task automatic wr(logic [19:0] a, logic [15:0] d, logic [1:0] be);
    issue(1, a, d, be);
    gold[int'(a)] = merge(gget(int'(a)), d, be);
  endtask

  task automatic rd(logic [19:0] a);
    logic [15:0] e;
    int n;
    e = gget(int'(a));
    issue(0, a, 16'h0, 2'b11);
    n = 0;
    while (!rsp_valid && n < 30) begin @(negedge clk); n++; end
    chk(rsp_valid, "R7 response arrives", rsp_valid, 1);
    chk(rsp_rdata == e, "R7 read data", rsp_rdata, e);
    @(negedge clk);
    chk(!rsp_valid, "R7 response single pulse", rsp_valid, 0);
  endtask

  initial begin
    logic [19:0] pool [16];
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    rel_cyc = cyc;
    // directed corners
    wr(20'hFFFFF, 16'hA55A, 2'b11); rd(20'hFFFFF);
    wr(20'h00000, 16'h1234, 2'b11); rd(20'h00000);
    wr(20'h00000, 16'hBEEF, 2'b01); rd(20'h00000);
    wr(20'h00000, 16'hCAFE, 2'b10); rd(20'h00000);
    wr(20'h00000, 16'h9999, 2'b00); rd(20'h00000);
    rd(20'hFFFFF);
    for (int i = 0; i < 16; i++) pool[i] = 20'($urandom);
    for (int i = 0; i < 700; i++) begin
      logic [19:0] a;
      a = pool[$urandom % 16];
      if ($urandom % 2) wr(a, 16'($urandom), 2'($urandom));
      else rd(a);
    end
    repeat (REF_INT + 40) @(negedge clk);
    chk(n_ref >= 2, "R8 refreshes seen", n_ref, 2);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule